// File: doc/BRIEF.md
# Oversample Timebase Divider with Converter Sync

This block turns high-rate oversample timebase ticks into per-group sample-clock enables for a set of sigma-delta converter groups. Each group has its own start, stop, integer divisor and timebase choice. All timebase sources appear as one-cycle tick enables inside a single clock domain. Source index 0 is taken as the fastest, typically the common 12.8 MHz oversample clock, and higher indices as slower. Every sample enable is a one-cycle pulse that lands on a tick of the group's source. It can also launch conversions in non-sigma-delta modules of the same task.

Only two converter sync lines exist, so at most two distinct timebases can be in use at once. A started group is bound to a line. It joins a line that already runs its timebase, or else it claims a free line. When neither is possible the start is rejected. Every accepted start fires a reset pulse on the line, and that pulse realigns every group bound to the line. A group's divider stays held while its line pulses. Requests are served one per cycle, lowest group index first. A group's select and divisor inputs are read in the cycle its request is served.

Group divider states: `GS_OFF` (idle), `GS_HOLD` (bound, waiting for the sync pulse to end), `GS_RUN` (counting ticks). The transitions are:
- `GS_OFF` to `GS_HOLD` on a grant.
- `GS_HOLD` to `GS_RUN` once the line's pulse is low.
- `GS_RUN` to `GS_HOLD` on a new grant or a realign.
- `GS_HOLD` or `GS_RUN` to `GS_OFF` on stop.

Sync generator states: `SY_IDLE` (line low) and `SY_PULSE` (line high). The transitions are:
- `SY_IDLE` to `SY_PULSE` on a trigger.
- `SY_PULSE` back to itself on a re-trigger, which restarts the width count.
- `SY_PULSE` to `SY_IDLE` after `SYNC_TICKS` ticks of the line's source.

Top module: `ostb_sync_divider`

## Requirements
- R1: With its force bit low, a group uses the lowest-index source whose `src_avail` bit is 1, or source 0 if none is.
- R2: With its force bit high, a group uses the source given in its `sel_idx_i` field (bits [g*SRC_W +: SRC_W]), whatever `src_avail` is.
- R3: An accepted start drives the bound line's `sync_o` bit high from the next cycle, and keeps it high for exactly `SYNC_TICKS` ticks of that line's source.
- R4: A group gives no sample enable while its line's sync is high. After the pulse ends, its first enable comes on the DIV-th tick of its source, and further enables follow every DIV ticks. DIV is the group's `div_i` field [g*DIV_W +: DIV_W].
- R5: A divisor of 0 or 1 gives a sample enable on every tick of the group's source.
- R6: A group whose `stop_i` bit is 1 gives no sample enable in that cycle or afterwards until restarted, and it releases its line.
- R7: A start whose timebase matches a line held by another group binds to that line. It fires a new pulse there, and all groups on that line restart their count after the pulse. Otherwise the start claims the lowest-index free line.
- R8: A start whose timebase matches neither held line while both lines are held by other groups is rejected. `reject_o` rises in the next cycle, and the group emits no sync pulse and no sample enable.
- R9: `reject_o` stays high until `reject_clr_i` is 1 in a cycle with no new rejection, and it is low from the next cycle.
- R10: A sample enable lasts one cycle and only occurs in a cycle where the group's source ticks.
- R11: While `rst_n` is low, `sync_o`, `samp_en_o` and `reject_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NUM_SRC | One-cycle tick per timebase source, index 0 fastest |
| src_avail | input | NUM_SRC | Sources present for default selection |
| start_i | input | NUM_GRP | Start (or restart) request per group |
| stop_i | input | NUM_GRP | Stop per group |
| sel_force_i | input | NUM_GRP | Use the explicit source index instead of the default |
| sel_idx_i | input | NUM_GRP*SRC_W | Explicit source index per group |
| div_i | input | NUM_GRP*DIV_W | Integer divisor per group |
| reject_clr_i | input | 1 | Clears the reject flag |
| sync_o | output | NUM_LINE | Converter reset pulse per sync line |
| samp_en_o | output | NUM_GRP | One-cycle sample-clock enable per group |
| reject_o | output | 1 | Sticky flag for a start that needed a third timebase |

## Verification
The bench counts ticks of each group's expected source from the end of its sync pulse. It matches every sample enable against queued ordinals. A divider that counted during the pulse, that was off by one, or that picked the wrong source would shift those ordinals. The pulse width is measured in source ticks, which catches a pulse that ends one tick early or late. A second group joins a running line, and this exposes any design that fails to realign the first group or that grabs a second line. A start that needs a third timebase must leave both lines and the group silent and set the flag. A design that evicts a running line, or that clears the flag on its own, fails that test.

// File: rtl/otd_pkg.sv
package otd_pkg;

    typedef enum logic [1:0] {
        GS_OFF  = 2'd0,
        GS_HOLD = 2'd1,
        GS_RUN  = 2'd2
    } grp_state_t;

    typedef enum logic {
        SY_IDLE  = 1'b0,
        SY_PULSE = 1'b1
    } sync_state_t;

endpackage

// File: rtl/otd_src_pick.sv
module otd_src_pick #(
    parameter int NUM_SRC = 3,
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] avail,
    input  logic               force_sel,
    input  logic [SRC_W-1:0]   force_idx,
    output logic [SRC_W-1:0]   pick
);

    logic [SRC_W-1:0] dflt;
    logic             dflt_found;

    // lowest index is the fastest source
    always_comb begin
        dflt       = '0;
        dflt_found = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (avail[s] && !dflt_found) begin
                dflt       = SRC_W'(s);
                dflt_found = 1'b1;
            end
        end
    end

    always_comb begin
        if (force_sel) begin
            pick = (int'(force_idx) < NUM_SRC) ? force_idx : '0;
        end else begin
            pick = dflt;
        end
    end

endmodule

// File: rtl/otd_slot_alloc.sv
module otd_slot_alloc #(
    parameter int NUM_SRC  = 3,
    parameter int NUM_GRP  = 3,
    parameter int NUM_LINE = 2,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int LINE_W = (NUM_LINE > 1) ? $clog2(NUM_LINE) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_GRP-1:0]                 req,
    input  logic [NUM_GRP-1:0][SRC_W-1:0]      want,
    input  logic [NUM_GRP-1:0]                 on,
    input  logic [NUM_GRP-1:0][LINE_W-1:0]     line,
    output logic [NUM_GRP-1:0]                 gnt,
    output logic [LINE_W-1:0]                  gnt_line,
    output logic [NUM_LINE-1:0]                trig,
    output logic                               rej,
    output logic [NUM_LINE-1:0][SRC_W-1:0]     line_src
);

    logic [GRP_W-1:0]    sel;
    logic                sel_found;
    logic [NUM_LINE-1:0] others;
    logic [LINE_W-1:0]   match_line;
    logic                match_found;
    logic [LINE_W-1:0]   free_line;
    logic                free_found;
    logic                grant_any;

    // one request served per cycle, lowest group first
    always_comb begin
        sel       = '0;
        sel_found = 1'b0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (req[g] && !sel_found) begin
                sel       = GRP_W'(g);
                sel_found = 1'b1;
            end
        end
    end

    // line usage by every group except the one being served
    always_comb begin
        others = '0;
        for (int s = 0; s < NUM_LINE; s++) begin
            for (int h = 0; h < NUM_GRP; h++) begin
                if (GRP_W'(h) != sel && on[h] && line[h] == LINE_W'(s)) begin
                    others[s] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        match_line  = '0;
        match_found = 1'b0;
        free_line   = '0;
        free_found  = 1'b0;
        for (int s = 0; s < NUM_LINE; s++) begin
            if (others[s] && line_src[s] == want[sel] && !match_found) begin
                match_line  = LINE_W'(s);
                match_found = 1'b1;
            end
            if (!others[s] && !free_found) begin
                free_line  = LINE_W'(s);
                free_found = 1'b1;
            end
        end
    end

    assign grant_any = sel_found && (match_found || free_found);
    assign gnt_line  = match_found ? match_line : free_line;
    assign rej       = sel_found && !match_found && !free_found;

    always_comb begin
        gnt  = '0;
        trig = '0;
        if (grant_any) begin
            gnt[sel]       = 1'b1;
            trig[gnt_line] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_src <= '0;
        end else if (grant_any) begin
            line_src[gnt_line] <= want[sel];
        end
    end

endmodule

// File: rtl/otd_sync_gen.sv
module otd_sync_gen
    import otd_pkg::*;
#(
    parameter int SYNC_TICKS = 1,
    parameter int SYNC_W     = 8,
    localparam int LAST = (SYNC_TICKS < 2) ? 0 : SYNC_TICKS - 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic tick,
    output logic sync
);

    sync_state_t       st_q, st_d;
    logic [SYNC_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            SY_IDLE: begin
                if (trig) begin
                    st_d  = SY_PULSE;
                    cnt_d = '0;
                end
            end
            SY_PULSE: begin
                if (trig) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == SYNC_W'(LAST)) begin
                        st_d  = SY_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                st_d  = SY_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SY_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        sync = (st_q == SY_PULSE);
    end

endmodule

// File: rtl/otd_grp_div.sv
module otd_grp_div
    import otd_pkg::*;
#(
    parameter int NUM_SRC  = 3,
    parameter int NUM_LINE = 2,
    parameter int DIV_W    = 16,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int LINE_W = (NUM_LINE > 1) ? $clog2(NUM_LINE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic [LINE_W-1:0] grant_line,
    input  logic [SRC_W-1:0]  grant_src,
    input  logic [DIV_W-1:0]  div_in,
    input  logic              realign,
    input  logic              stop,
    input  logic              line_sync,
    input  logic              tick,
    output logic              on,
    output logic [LINE_W-1:0] line_q,
    output logic [SRC_W-1:0]  src_q,
    output logic              samp_en
);

    grp_state_t       st_q, st_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] div_q;
    logic             fire;

    assign fire = (div_q <= DIV_W'(1)) || (cnt_q == div_q - 1'b1);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            GS_OFF: begin
                cnt_d = '0;
                if (grant && !stop) begin
                    st_d = GS_HOLD;
                end
            end
            GS_HOLD: begin
                cnt_d = '0;
                if (stop) begin
                    st_d = GS_OFF;
                end else if (!grant && !realign && !line_sync) begin
                    st_d = GS_RUN;
                end
            end
            GS_RUN: begin
                if (stop) begin
                    st_d  = GS_OFF;
                    cnt_d = '0;
                end else if (grant || realign) begin
                    st_d  = GS_HOLD;
                    cnt_d = '0;
                end else if (tick) begin
                    cnt_d = fire ? '0 : cnt_q + 1'b1;
                end
            end
            default: begin
                st_d  = GS_OFF;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= GS_OFF;
            cnt_q  <= '0;
            div_q  <= '0;
            line_q <= '0;
            src_q  <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (grant && !stop) begin
                div_q  <= div_in;
                line_q <= grant_line;
                src_q  <= grant_src;
            end
        end
    end

    always_comb begin
        on      = (st_q != GS_OFF);
        samp_en = (st_q == GS_RUN) && tick && fire && !stop && !grant && !realign;
    end

endmodule

// File: rtl/ostb_sync_divider.sv
module ostb_sync_divider #(
    parameter int NUM_SRC    = 3,
    parameter int NUM_GRP    = 3,
    parameter int NUM_LINE   = 2,
    parameter int DIV_W      = 16,
    parameter int SYNC_TICKS = 1,
    parameter int SYNC_W     = 8,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int LINE_W = (NUM_LINE > 1) ? $clog2(NUM_LINE) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_tick,
    input  logic [NUM_SRC-1:0]         src_avail,
    input  logic [NUM_GRP-1:0]         start_i,
    input  logic [NUM_GRP-1:0]         stop_i,
    input  logic [NUM_GRP-1:0]         sel_force_i,
    input  logic [NUM_GRP*SRC_W-1:0]   sel_idx_i,
    input  logic [NUM_GRP*DIV_W-1:0]   div_i,
    input  logic                       reject_clr_i,
    output logic [NUM_LINE-1:0]        sync_o,
    output logic [NUM_GRP-1:0]         samp_en_o,
    output logic                       reject_o
);

    logic [NUM_GRP-1:0]                 pend_q;
    logic [NUM_GRP-1:0]                 req;
    logic [NUM_GRP-1:0][SRC_W-1:0]      want_src;
    logic [NUM_GRP-1:0]                 grp_on;
    logic [NUM_GRP-1:0][LINE_W-1:0]     grp_line;
    logic [NUM_GRP-1:0][SRC_W-1:0]      grp_src;
    logic [NUM_GRP-1:0]                 gnt;
    logic [NUM_GRP-1:0]                 realign;
    logic [NUM_GRP-1:0]                 served;
    logic [LINE_W-1:0]                  gnt_line;
    logic [NUM_LINE-1:0]                trig;
    logic [NUM_LINE-1:0][SRC_W-1:0]     line_src;
    logic [NUM_LINE-1:0]                line_tick;
    logic                               rej_evt;
    logic                               rej_q;

    assign req = (pend_q | start_i) & ~stop_i;

    // a rejected or granted request is consumed; only one per cycle
    always_comb begin
        served = gnt;
        if (rej_evt) begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (req[g] && ((req & ((NUM_GRP)'(1) << g) - 1'b1) == '0)) begin
                    served[g] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            rej_q  <= 1'b0;
        end else begin
            pend_q <= req & ~served;
            if (rej_evt) begin
                rej_q <= 1'b1;
            end else if (reject_clr_i) begin
                rej_q <= 1'b0;
            end
        end
    end

    otd_slot_alloc #(
        .NUM_SRC (NUM_SRC),
        .NUM_GRP (NUM_GRP),
        .NUM_LINE(NUM_LINE)
    ) u_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .want    (want_src),
        .on      (grp_on),
        .line    (grp_line),
        .gnt     (gnt),
        .gnt_line(gnt_line),
        .trig    (trig),
        .rej     (rej_evt),
        .line_src(line_src)
    );

    for (genvar s = 0; s < NUM_LINE; s++) begin : g_line
        assign line_tick[s] = src_tick[line_src[s]];

        otd_sync_gen #(
            .SYNC_TICKS(SYNC_TICKS),
            .SYNC_W    (SYNC_W)
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .trig (trig[s]),
            .tick (line_tick[s]),
            .sync (sync_o[s])
        );
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic grp_tick;
        logic grp_sync;

        otd_src_pick #(
            .NUM_SRC(NUM_SRC)
        ) u_pick (
            .avail    (src_avail),
            .force_sel(sel_force_i[g]),
            .force_idx(sel_idx_i[g*SRC_W +: SRC_W]),
            .pick     (want_src[g])
        );

        assign grp_tick   = src_tick[grp_src[g]];
        assign grp_sync   = sync_o[grp_line[g]];
        assign realign[g] = grp_on[g] && !gnt[g] && trig[grp_line[g]];

        otd_grp_div #(
            .NUM_SRC (NUM_SRC),
            .NUM_LINE(NUM_LINE),
            .DIV_W   (DIV_W)
        ) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .grant     (gnt[g]),
            .grant_line(gnt_line),
            .grant_src (want_src[g]),
            .div_in    (div_i[g*DIV_W +: DIV_W]),
            .realign   (realign[g]),
            .stop      (stop_i[g]),
            .line_sync (grp_sync),
            .tick      (grp_tick),
            .on        (grp_on[g]),
            .line_q    (grp_line[g]),
            .src_q     (grp_src[g]),
            .samp_en   (samp_en_o[g])
        );
    end

    assign reject_o = rej_q;

endmodule

// File: rtl/otd_checker.sv
module otd_checker #(
    parameter int NUM_SRC  = 3,
    parameter int NUM_GRP  = 3,
    parameter int NUM_LINE = 2,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int LINE_W = (NUM_LINE > 1) ? $clog2(NUM_LINE) : 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_SRC-1:0]             src_tick,
    input logic [NUM_GRP-1:0]             stop_i,
    input logic                           reject_clr_i,
    input logic [NUM_LINE-1:0]            sync_o,
    input logic [NUM_GRP-1:0]             samp_en_o,
    input logic                           reject_o,
    input logic [NUM_GRP-1:0]             grp_on,
    input logic [NUM_GRP-1:0][LINE_W-1:0] grp_line,
    input logic [NUM_GRP-1:0][SRC_W-1:0]  grp_src,
    input logic [NUM_LINE-1:0]            trig,
    input logic                           rej_evt
);

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (sync_o == '0 && samp_en_o == '0 && !reject_o));

    // R8
    reject_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rej_evt |=> reject_o);

    // R9
    reject_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reject_o && !reject_clr_i) |=> reject_o);

    // R9
    reject_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reject_clr_i && !rej_evt) |=> !reject_o);

    for (genvar s = 0; s < NUM_LINE; s++) begin : g_line_chk
        // R3
        sync_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sync_o[s]) |-> $past(trig[s]));
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp_chk
        // R6
        stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            stop_i[g] |-> !samp_en_o[g]);

        // R4
        hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_on[g] && sync_o[grp_line[g]]) |-> !samp_en_o[g]);

        // R10
        on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            samp_en_o[g] |-> src_tick[grp_src[g]]);
    end

endmodule

bind ostb_sync_divider otd_checker #(
    .NUM_SRC (NUM_SRC),
    .NUM_GRP (NUM_GRP),
    .NUM_LINE(NUM_LINE)
) u_otd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_tick    (src_tick),
    .stop_i      (stop_i),
    .reject_clr_i(reject_clr_i),
    .sync_o      (sync_o),
    .samp_en_o   (samp_en_o),
    .reject_o    (reject_o),
    .grp_on      (grp_on),
    .grp_line    (grp_line),
    .grp_src     (grp_src),
    .trig        (trig),
    .rej_evt     (rej_evt)
);

// File: tb/ostb_sync_divider_bench.sv
module ostb_sync_divider_bench;

    localparam int NS     = 3;
    localparam int NG     = 3;
    localparam int NL     = 2;
    localparam int DW     = 16;
    localparam int SYNC_T = 2;
    localparam int SW     = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   src_tick = '0;
    logic [NS-1:0]   src_avail = '1;
    logic [NG-1:0]   start_i = '0;
    logic [NG-1:0]   stop_i = '0;
    logic [NG-1:0]   sel_force_i = '0;
    logic [NG*SW-1:0] sel_idx_i = '0;
    logic [NG*DW-1:0] div_i = '0;
    logic            reject_clr_i = 1'b0;
    logic [NL-1:0]   sync_o;
    logic [NG-1:0]   samp_en_o;
    logic            reject_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // per-group monitor state: 0 stopped, 1 waiting on sync, 2 checked run, 3 unchecked run
    int ph    [NG];
    int eline [NG];
    int esrc  [NG];
    int seen  [NG];
    int scnt  [NG];
    int kcnt  [NG];
    int exp_q [NG][$];

    ostb_sync_divider #(
        .NUM_SRC   (NS),
        .NUM_GRP   (NG),
        .NUM_LINE  (NL),
        .DIV_W     (DW),
        .SYNC_TICKS(SYNC_T),
        .SYNC_W    (8)
    ) u_ostb_sync_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_tick    (src_tick),
        .src_avail   (src_avail),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .sel_force_i (sel_force_i),
        .sel_idx_i   (sel_idx_i),
        .div_i       (div_i),
        .reject_clr_i(reject_clr_i),
        .sync_o      (sync_o),
        .samp_en_o   (samp_en_o),
        .reject_o    (reject_o)
    );

    always #10 clk = ~clk;

    // sources: 0 every 2 cycles, 1 every 3, 2 every 4
    always @(posedge clk) begin
        #1;
        cyc++;
        src_tick[0] = (cyc % 2 == 0);
        src_tick[1] = (cyc % 3 == 0);
        src_tick[2] = (cyc % 4 == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: scoreboard consumer
    always @(negedge clk) begin
        if (rst_n) begin
            for (int g = 0; g < NG; g++) begin
                case (ph[g])
                    0: if (samp_en_o[g]) check(1'b0, "R6 enable while stopped", 1, 0);
                    1: begin
                        if (samp_en_o[g]) check(1'b0, "R4 enable during sync", 1, 0);
                        if (sync_o[eline[g]]) begin
                            seen[g] = 1;
                            if (src_tick[esrc[g]]) scnt[g]++;
                        end else if (seen[g] != 0) begin
                            check(scnt[g] == SYNC_T, "R3 sync width in ticks", scnt[g], SYNC_T);
                            ph[g]   = 2;
                            kcnt[g] = 0;
                        end
                    end
                    2: begin
                        if (src_tick[esrc[g]]) kcnt[g]++;
                        if (samp_en_o[g]) begin
                            if (!src_tick[esrc[g]]) begin
                                check(1'b0, "R10 enable off tick", 0, 1);
                            end else if (exp_q[g].size() == 0) begin
                                check(1'b0, "R4 unexpected enable ordinal", kcnt[g], 0);
                            end else begin
                                int e;
                                e = exp_q[g].pop_front();
                                check(kcnt[g] == e, "R4 R5 enable ordinal", kcnt[g], e);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic arm(input int g, input int line, input int src, input int dv, input int n);
        ph[g]    = 1;
        eline[g] = line;
        esrc[g]  = src;
        seen[g]  = 0;
        scnt[g]  = 0;
        exp_q[g].delete();
        for (int i = 1; i <= n; i++) exp_q[g].push_back((dv <= 1) ? i : i * dv);
    endtask

    task automatic set_cfg(input int g, input bit frc, input int idx, input int dv);
        sel_force_i[g]          = frc;
        sel_idx_i[g*SW +: SW]   = SW'(idx);
        div_i[g*DW +: DW]       = DW'(dv);
    endtask

    task automatic pulse_start(input int g);
        @(posedge clk); #1;
        start_i[g] = 1'b1;
        @(posedge clk); #1;
        start_i[g] = 1'b0;
    endtask

    task automatic pulse_stop(input int g);
        @(posedge clk); #1;
        stop_i[g] = 1'b1;
        ph[g]     = 0;
        @(posedge clk); #1;
        stop_i[g] = 1'b0;
    endtask

    task automatic wait_done(input int g, input string req);
        int t;
        t = 0;
        while (exp_q[g].size() != 0 && t < 600) begin
            @(posedge clk);
            t++;
        end
        check(exp_q[g].size() == 0, req, exp_q[g].size(), 0);
        ph[g] = 3;
    endtask

    initial begin
        for (int g = 0; g < NG; g++) begin
            ph[g] = 0; eline[g] = 0; esrc[g] = 0; seen[g] = 0; scnt[g] = 0; kcnt[g] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        check(sync_o == '0, "R11 sync in reset", int'(sync_o), 0);
        check(samp_en_o == '0, "R11 enable in reset", int'(samp_en_o), 0);
        check(reject_o == 1'b0, "R11 reject in reset", int'(reject_o), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1 default picks source 0, divisor 4, line 0
        set_cfg(0, 1'b0, 0, 4);
        arm(0, 0, 0, 4, 4);
        pulse_start(0);
        wait_done(0, "R1 R4 default source div 4");

        // R6 stop then silence and line release
        pulse_stop(0);
        repeat (30) @(posedge clk);
        #1;
        check(samp_en_o[0] == 1'b0, "R6 after stop", int'(samp_en_o[0]), 0);

        // R1 default with source 0 absent picks source 1, claims line 0
        src_avail = 3'b110;
        set_cfg(1, 1'b0, 0, 3);
        arm(1, 0, 1, 3, 3);
        pulse_start(1);
        wait_done(1, "R1 default source 1");

        // R2 R5 forced source 2, divisor 1, second line
        set_cfg(2, 1'b1, 2, 1);
        arm(2, 1, 2, 1, 6);
        pulse_start(2);
        wait_done(2, "R2 R5 forced source div 1");
        pulse_stop(2);

        // R5 divisor 0 on freed line 1
        set_cfg(0, 1'b1, 2, 0);
        arm(0, 1, 2, 0, 5);
        pulse_start(0);
        wait_done(0, "R5 div 0");

        // R8 third timebase rejected
        set_cfg(2, 1'b1, 0, 2);
        pulse_start(2);
        #1;
        check(reject_o == 1'b1, "R8 reject raised", int'(reject_o), 1);
        begin
            int rises;
            logic [NL-1:0] prev;
            rises = 0;
            prev  = sync_o;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if ((sync_o & ~prev) != '0) rises++;
                prev = sync_o;
            end
            check(rises == 0, "R8 no sync after reject", rises, 0);
        end
        check(reject_o == 1'b1, "R9 reject sticky", int'(reject_o), 1);

        // R9 clear
        @(posedge clk); #1;
        reject_clr_i = 1'b1;
        @(posedge clk); #1;
        reject_clr_i = 1'b0;
        check(reject_o == 1'b0, "R9 reject cleared", int'(reject_o), 0);

        // R7 group 2 joins line 0 on source 1, group 1 realigns
        set_cfg(2, 1'b1, 1, 2);
        @(posedge clk); #1;
        arm(2, 0, 1, 2, 4);
        arm(1, 0, 1, 3, 3);
        start_i[2] = 1'b1;
        @(posedge clk); #1;
        start_i[2] = 1'b0;
        wait_done(2, "R7 joined group");
        wait_done(1, "R7 realigned group");
        check(sync_o[1] == 1'b0, "R7 no second line used", int'(sync_o[1]), 0);

        pulse_stop(0);
        pulse_stop(1);
        pulse_stop(2);
        repeat (10) @(posedge clk);
        #1;
        check(samp_en_o == '0, "R6 all stopped", int'(samp_en_o), 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule